// File: doc/BRIEF.md
# Fail-safe cause capture

This block keeps a record of what drove a supply-supervision controller into its fail-safe state. Five fault sources arrive as single-cycle pulses: watchdog failure, severe overtemperature, supply short to ground, supply undervoltage and supply overvoltage. The block decides whether each pulse qualifies as a fail-safe cause. When one does, it raises a one-cycle fail-safe request. It also latches sticky cause flags, which software reads once the controller is back in normal operation.

A read strobe with clear semantics empties the record. Two configuration bits decide whether an overvoltage escalates to fail-safe. A mode input says whether the controller was in normal or stop mode. Capture does not depend on that mode. The mode seen at the latest fail-safe entry is kept in one extra flag.

Top module: `fs_cause_capture`

## Requirements
- R1: After reset all outputs are 0: the device-status field, the watchdog field, every flag, the mode flag and the fail-safe request.
- R2: Each fail-safe entry sets the device-status field to binary 01 in the cycle after the qualifying pulse. The field keeps that value until a clearing read.
- R3: The watchdog field (`wd_fail_cnt`) reads 01 after one watchdog failure and 10 after two failures in a row. It saturates at 10 and never reads 11. A failure causes fail-safe only when it brings the count to 2 or more (parameter `WD_FS_FAILS`, default 2).
- R4: A watchdog service pulse returns the watchdog field to 00. A failure in the same cycle as a service gives 01.
- R5: A severe overtemperature pulse sets `flag_tsd` and causes fail-safe.
- R6: A short-to-ground pulse sets both `flag_short` and `flag_uv` and causes fail-safe.
- R7: Every undervoltage pulse sets `flag_uv`. The fourth pulse counted since reset, the last clearing read or the last undervoltage escalation (parameter `UV_FS_COUNT`) also sets `flag_uv_fs` and causes fail-safe. The count then restarts.
- R8: An overvoltage pulse always sets `flag_ov`. It causes fail-safe only when `cfg_ov_rst_en` is 1 and `cfg_sel` is 0.
- R9: All flags and both status fields are sticky. A cycle with `rd_clr` high zeroes them all, together with the undervoltage count. A fault pulse in that same cycle is still recorded.
- R10: Capture is the same whether `mode_stop` is 0 or 1. At each fail-safe entry, `fs_from_stop` takes the value `mode_stop` had in the qualifying cycle.
- R11: `fs_req` is high for exactly one cycle, the cycle after any cycle that holds at least one qualifying cause. Several causes in one cycle give a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_wd_fail | input | 1 | Watchdog failure pulse |
| wd_service | input | 1 | Successful watchdog service pulse |
| ev_tsd | input | 1 | Severe overtemperature pulse |
| ev_short | input | 1 | Supply short-to-ground pulse |
| ev_uv | input | 1 | Supply undervoltage pulse |
| ev_ov | input | 1 | Supply overvoltage pulse |
| cfg_ov_rst_en | input | 1 | Overvoltage escalation enable |
| cfg_sel | input | 1 | Configuration select; 0 permits overvoltage escalation |
| mode_stop | input | 1 | 1 = stop mode, 0 = normal mode |
| rd_clr | input | 1 | Status read strobe; clears the record |
| dev_stat | output | 2 | Device status; 01 after a fail-safe entry |
| wd_fail_cnt | output | 2 | Watchdog failure field |
| flag_tsd | output | 1 | Overtemperature cause |
| flag_short | output | 1 | Short-to-ground cause |
| flag_uv | output | 1 | Undervoltage seen |
| flag_uv_fs | output | 1 | Repeated-undervoltage cause |
| flag_ov | output | 1 | Overvoltage seen |
| fs_from_stop | output | 1 | Mode at the latest fail-safe entry |
| fs_req | output | 1 | One-cycle fail-safe entry request |

## Verification
The assertions assume that each fault input is a clean pulse sampled on the clock. They also assume that the configuration bits change only while no overvoltage pulse is present. The overvoltage no-escalation property also relies on no other cause arriving in the same cycle, and it is stated with that guard. The stimulus changes inputs only on the falling edge, holds configuration and mode steady across each clear-and-pulse pair, and releases every pulse after one cycle.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam logic [1:0] DEV_STAT_IDLE = 2'b00;
  localparam logic [1:0] DEV_STAT_FS   = 2'b01;
  localparam logic [1:0] WD_CNT_SAT    = 2'b10;

  typedef struct packed {
    logic tsd;
    logic short_gnd;
    logic uv;
    logic uv_fs;
    logic ov;
  } cause_flags_t;
endpackage

// File: rtl/fsc_wd_tracker.sv
module fsc_wd_tracker #(
  parameter int WD_FS_FAILS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fail,
  input  logic       service,
  input  logic       clr,
  output logic [1:0] cnt,
  output logic       fs_hit
);
  import fsc_pkg::*;

  localparam logic [1:0] FS_LEVEL = 2'(WD_FS_FAILS);

  logic [1:0] cnt_q, cnt_base, cnt_d;

  always_comb begin
    cnt_base = (service || clr) ? 2'b00 : cnt_q;
    cnt_d    = cnt_base;
    fs_hit   = 1'b0;
    if (fail) begin
      cnt_d  = (cnt_base >= WD_CNT_SAT) ? WD_CNT_SAT : cnt_base + 2'b01;
      fs_hit = (cnt_d >= FS_LEVEL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'b00;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/fsc_uv_tracker.sv
module fsc_uv_tracker #(
  parameter int UV_FS_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv,
  input  logic clr,
  output logic fs_hit
);
  localparam int CW = (UV_FS_COUNT > 2) ? $clog2(UV_FS_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(UV_FS_COUNT - 1);

  logic [CW-1:0] n_q, n_base, n_d;

  always_comb begin
    n_base = clr ? '0 : n_q;
    n_d    = n_base;
    fs_hit = 1'b0;
    if (uv) begin
      if (n_base == LAST) begin
        n_d    = '0;
        fs_hit = 1'b1;
      end else begin
        n_d = n_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_q <= '0;
    else        n_q <= n_d;
  end
endmodule

// File: rtl/fsc_cause_decode.sv
module fsc_cause_decode (
  input  logic                 ev_tsd,
  input  logic                 ev_short,
  input  logic                 ev_uv,
  input  logic                 ev_ov,
  input  logic                 cfg_ov_rst_en,
  input  logic                 cfg_sel,
  input  logic                 wd_hit,
  input  logic                 uv_hit,
  output fsc_pkg::cause_flags_t set_flags,
  output logic                 fs_now
);
  logic ov_escalates;

  always_comb begin
    ov_escalates        = ev_ov && cfg_ov_rst_en && !cfg_sel;
    set_flags.tsd       = ev_tsd;
    set_flags.short_gnd = ev_short;
    set_flags.uv        = ev_uv || ev_short;
    set_flags.uv_fs     = uv_hit;
    set_flags.ov        = ev_ov;
    fs_now              = ev_tsd || ev_short || uv_hit || wd_hit || ov_escalates;
  end
endmodule

// File: rtl/fs_cause_capture.sv
module fs_cause_capture #(
  parameter int WD_FS_FAILS = 2,
  parameter int UV_FS_COUNT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_wd_fail,
  input  logic       wd_service,
  input  logic       ev_tsd,
  input  logic       ev_short,
  input  logic       ev_uv,
  input  logic       ev_ov,
  input  logic       cfg_ov_rst_en,
  input  logic       cfg_sel,
  input  logic       mode_stop,
  input  logic       rd_clr,
  output logic [1:0] dev_stat,
  output logic [1:0] wd_fail_cnt,
  output logic       flag_tsd,
  output logic       flag_short,
  output logic       flag_uv,
  output logic       flag_uv_fs,
  output logic       flag_ov,
  output logic       fs_from_stop,
  output logic       fs_req
);
  import fsc_pkg::*;

  logic         wd_hit, uv_hit, fs_now;
  cause_flags_t set_flags, flags_q, flags_d;
  logic [1:0]   dev_q, dev_d;
  logic         stop_q, stop_d, req_q;

  fsc_wd_tracker #(.WD_FS_FAILS(WD_FS_FAILS)) wd_i (
    .clk(clk), .rst_n(rst_n), .fail(ev_wd_fail), .service(wd_service),
    .clr(rd_clr), .cnt(wd_fail_cnt), .fs_hit(wd_hit)
  );

  fsc_uv_tracker #(.UV_FS_COUNT(UV_FS_COUNT)) uv_i (
    .clk(clk), .rst_n(rst_n), .uv(ev_uv), .clr(rd_clr), .fs_hit(uv_hit)
  );

  fsc_cause_decode dec_i (
    .ev_tsd(ev_tsd), .ev_short(ev_short), .ev_uv(ev_uv), .ev_ov(ev_ov),
    .cfg_ov_rst_en(cfg_ov_rst_en), .cfg_sel(cfg_sel),
    .wd_hit(wd_hit), .uv_hit(uv_hit), .set_flags(set_flags), .fs_now(fs_now)
  );

  always_comb begin
    flags_d = (rd_clr ? '0 : flags_q) | set_flags;
    dev_d   = rd_clr ? DEV_STAT_IDLE : dev_q;
    stop_d  = rd_clr ? 1'b0 : stop_q;
    if (fs_now) begin
      dev_d  = DEV_STAT_FS;
      stop_d = mode_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      dev_q   <= DEV_STAT_IDLE;
      stop_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      dev_q   <= dev_d;
      stop_q  <= stop_d;
      req_q   <= fs_now;
    end
  end

  assign dev_stat     = dev_q;
  assign flag_tsd     = flags_q.tsd;
  assign flag_short   = flags_q.short_gnd;
  assign flag_uv      = flags_q.uv;
  assign flag_uv_fs   = flags_q.uv_fs;
  assign flag_ov      = flags_q.ov;
  assign fs_from_stop = stop_q;
  assign fs_req       = req_q;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_wd_fail,
  input logic       wd_service,
  input logic       ev_tsd,
  input logic       ev_short,
  input logic       ev_uv,
  input logic       ev_ov,
  input logic       cfg_ov_rst_en,
  input logic       rd_clr,
  input logic [1:0] dev_stat,
  input logic [1:0] wd_fail_cnt,
  input logic       flag_tsd,
  input logic       flag_short,
  input logic       flag_uv,
  input logic       flag_uv_fs,
  input logic       flag_ov,
  input logic       fs_req
);
  // R2
  fs_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_req |-> dev_stat == 2'b01);
  // R3
  wd_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fail_cnt != 2'b11);
  // R4
  wd_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_service && !ev_wd_fail) |=> wd_fail_cnt == 2'b00);
  // R5
  tsd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tsd |=> (flag_tsd && fs_req));
  // R6
  short_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_short |=> (flag_short && flag_uv && fs_req));
  // R7
  uv_fs_implies_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_uv_fs |-> flag_uv);
  // R8
  ov_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ov |=> flag_ov);
  // R8
  ov_no_escalate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ov && !cfg_ov_rst_en && !ev_wd_fail && !ev_uv && !ev_tsd && !ev_short)
      |=> !fs_req);
  // R9
  tsd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_tsd && !rd_clr) |=> flag_tsd);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !ev_wd_fail && !ev_tsd && !ev_short && !ev_uv && !ev_ov)
      |=> (dev_stat == 2'b00 && wd_fail_cnt == 2'b00 && !flag_ov && !flag_uv_fs));
endmodule

bind fs_cause_capture fsc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ev_wd_fail(ev_wd_fail), .wd_service(wd_service),
  .ev_tsd(ev_tsd), .ev_short(ev_short), .ev_uv(ev_uv), .ev_ov(ev_ov),
  .cfg_ov_rst_en(cfg_ov_rst_en), .rd_clr(rd_clr), .dev_stat(dev_stat),
  .wd_fail_cnt(wd_fail_cnt), .flag_tsd(flag_tsd), .flag_short(flag_short),
  .flag_uv(flag_uv), .flag_uv_fs(flag_uv_fs), .flag_ov(flag_ov), .fs_req(fs_req)
);

// File: tb/fs_cause_capture_tb_top.sv
module fs_cause_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_wd_fail = 0, wd_service = 0, ev_tsd = 0, ev_short = 0, ev_uv = 0, ev_ov = 0;
  logic cfg_ov_rst_en = 0, cfg_sel = 0, mode_stop = 0, rd_clr = 0;
  logic [1:0] dev_stat, wd_fail_cnt;
  logic flag_tsd, flag_short, flag_uv, flag_uv_fs, flag_ov, fs_from_stop, fs_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fs_cause_capture dut_i (
    .clk(clk), .rst_n(rst_n), .ev_wd_fail(ev_wd_fail), .wd_service(wd_service),
    .ev_tsd(ev_tsd), .ev_short(ev_short), .ev_uv(ev_uv), .ev_ov(ev_ov),
    .cfg_ov_rst_en(cfg_ov_rst_en), .cfg_sel(cfg_sel), .mode_stop(mode_stop),
    .rd_clr(rd_clr), .dev_stat(dev_stat), .wd_fail_cnt(wd_fail_cnt),
    .flag_tsd(flag_tsd), .flag_short(flag_short), .flag_uv(flag_uv),
    .flag_uv_fs(flag_uv_fs), .flag_ov(flag_ov), .fs_from_stop(fs_from_stop),
    .fs_req(fs_req)
  );

  // observation vector: {from_stop, fs_req, dev_stat[1:0], wd[1:0], tsd, short, uv, uv_fs, ov}
  function automatic logic [10:0] obs();
    return {fs_from_stop, fs_req, dev_stat, wd_fail_cnt,
            flag_tsd, flag_short, flag_uv, flag_uv_fs, flag_ov};
  endfunction

  task automatic chk(input string tag, input logic [10:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, obs(), exp);
    end
  endtask

  // ev bits: [0] wd fail, [1] tsd, [2] short, [3] uv, [4] ov
  task automatic step(input logic [4:0] ev, input logic clr, input logic svc);
    @(negedge clk);
    ev_wd_fail = ev[0]; ev_tsd = ev[1]; ev_short = ev[2]; ev_uv = ev[3]; ev_ov = ev[4];
    rd_clr = clr; wd_service = svc;
    @(negedge clk);
    ev_wd_fail = 0; ev_tsd = 0; ev_short = 0; ev_uv = 0; ev_ov = 0;
    rd_clr = 0; wd_service = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog timeout R11 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 11'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 11'b0);

    // R10 R8 R5 R6 R2 R9: exhaustive sweep over config, mode and cause combinations
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int md = 0; md < 2; md++) begin
        for (int e = 0; e < 32; e++) begin
          logic [4:0] ev;
          logic fs, en, sel;
          ev = 5'(e);
          en = cfg[0]; sel = cfg[1];
          @(negedge clk);
          cfg_ov_rst_en = en; cfg_sel = sel; mode_stop = md[0];
          step(5'b0, 1'b1, 1'b0);
          chk("R9 cleared", 11'b0);
          step(ev, 1'b0, 1'b0);
          fs = ev[1] | ev[2] | (ev[4] & en & ~sel);
          chk("R10 R8 R5 R6 sweep",
              {fs & md[0], fs, fs ? 2'b01 : 2'b00, {1'b0, ev[0]},
               ev[1], ev[2], ev[2] | ev[3], 1'b0, ev[4]});
        end
      end
    end
    @(negedge clk);
    cfg_ov_rst_en = 0; cfg_sel = 0; mode_stop = 0;

    // R3 watchdog counting and saturation
    step(5'b0, 1'b1, 1'b0);
    step(5'b00001, 1'b0, 1'b0);
    chk("R3 first wd failure", {1'b0, 1'b0, 2'b00, 2'b01, 5'b0});
    step(5'b00001, 1'b0, 1'b0);
    chk("R3 second wd failure", {1'b0, 1'b1, 2'b01, 2'b10, 5'b0});
    step(5'b00001, 1'b0, 1'b0);
    chk("R3 third wd failure saturates", {1'b0, 1'b1, 2'b01, 2'b10, 5'b0});
    // R4 service
    step(5'b0, 1'b0, 1'b1);
    chk("R4 service resets wd", {1'b0, 1'b0, 2'b01, 2'b00, 5'b0});
    step(5'b00010, 1'b0, 1'b0);
    step(5'b00001, 1'b0, 1'b1);
    chk("R4 fail with service", {1'b0, 1'b0, 2'b01, 2'b01, 5'b10000});

    // R7 repeated undervoltage
    step(5'b0, 1'b1, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      step(5'b01000, 1'b0, 1'b0);
      chk("R7 uv below count", {1'b0, 1'b0, 2'b00, 2'b00, 5'b00100});
    end
    @(negedge clk); mode_stop = 1;
    step(5'b01000, 1'b0, 1'b0);
    chk("R7 fourth uv", {1'b1, 1'b1, 2'b01, 2'b00, 5'b00110});
    @(negedge clk); mode_stop = 0;
    step(5'b01000, 1'b0, 1'b0);
    chk("R7 count restarted", {1'b1, 1'b0, 2'b01, 2'b00, 5'b00110});
    // R7 clear resets the count
    step(5'b01000, 1'b0, 1'b0);
    step(5'b01000, 1'b1, 1'b0);
    step(5'b01000, 1'b0, 1'b0);
    step(5'b01000, 1'b0, 1'b0);
    chk("R7 clear restarts count", {1'b0, 1'b0, 2'b00, 2'b00, 5'b00100});
    step(5'b01000, 1'b0, 1'b0);
    chk("R7 fourth after clear", {1'b0, 1'b1, 2'b01, 2'b00, 5'b00110});

    // R9 stickiness and clear coincident with an event
    step(5'b0, 1'b1, 1'b0);
    step(5'b00010, 1'b0, 1'b0);
    step(5'b0, 1'b0, 1'b0);
    step(5'b0, 1'b0, 1'b0);
    chk("R9 sticky after idle", {1'b0, 1'b0, 2'b01, 2'b00, 5'b10000});
    step(5'b10000, 1'b1, 1'b0);
    chk("R9 event wins over clear", {1'b0, 1'b0, 2'b00, 2'b00, 5'b00001});

    // R11 several causes in one cycle give a single pulse
    step(5'b0, 1'b1, 1'b0);
    step(5'b00110, 1'b0, 1'b0);
    chk("R11 combined causes", {1'b0, 1'b1, 2'b01, 2'b00, 5'b11100});
    step(5'b0, 1'b0, 1'b0);
    chk("R11 pulse one cycle", {1'b0, 1'b0, 2'b01, 2'b00, 5'b11100});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule